// File: doc/BRIEF.md
# Power-of-Two Prescaled Backlight PWM

This block drives one pulse-width-modulated output, typically a display backlight. Software programs a 16-bit configuration word with an 8-bit compare value, an output polarity and a 3-bit exponent that divides the chosen tick source by a power of two. A level input picks the tick source: a slow reference tick or a system tick. Both sources are clock enables in the block's own clock domain, so nothing here switches or gates a clock.

A period always lasts 256 prescaled ticks, and the output is active for the first `compare` of them. This gives duty cycles from 0/256 to 255/256, so a fully-on output is not possible. Compare, polarity and exponent changes are held in a shadow copy while running and applied only when the period counter wraps. Start and stop are write-one strobes. A status output confirms each one after a fixed handshake latency, and software polls it.

Top module: `pwm_backlight`

## Requirements
- R1: The configuration word holds the compare value in bits 15:8, the polarity in bit 4 and the prescaler exponent in bits 2:0. Its reset value is 0x0010 (compare 0, polarity 1, exponent 0).
- R2: After reset, `statusRun` is 0 and `pwmOut` is 0.
- R3: While running, the output is active while the 8-bit period counter is below the compare value. Over one period it is active for exactly `compare` prescaled ticks, so compare 0 is never active and compare 255 is active for 255 of 256 ticks.
- R4: Polarity 1 drives the active level as 1. Polarity 0 inverts the output.
- R5: An exponent N advances the period counter once every 2^N source ticks, so one period spans 256·2^N source ticks.
- R6: Exponent 7 behaves exactly like exponent 6.
- R7: With `srcSys` at 1 the source ticks are `sysTick`; with `srcSys` at 0 they are `slowTick`.
- R8: While running, a configuration write takes effect only at the next period wrap. The period in progress completes with the old values.
- R9: An enable strobe from the stopped state raises `statusRun` LAT+1 clock edges after the edge that samples the strobe, counting that edge. `statusRun` stays 0 in between.
- R10: A disable strobe while running forces the output inactive from the next edge and clears the counters. `statusRun` stays 1 and falls LAT+1 edges after the strobe edge.
- R11: While not running, `pwmOut` holds the inactive level of the written polarity. It is 0 for polarity 1 and 1 for polarity 0, and follows a write within two edges.
- R12: If enable and disable strobe in the same cycle, disable wins and the generator does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgWdata | input | 16 | Configuration word data |
| srcSys | input | 1 | Tick source select: 1 system tick, 0 slow tick |
| slowTick | input | 1 | Slow reference tick enable |
| sysTick | input | 1 | System tick enable |
| enStrobe | input | 1 | Write-one start strobe |
| disStrobe | input | 1 | Write-one stop strobe |
| statusRun | output | 1 | Running status for polling |
| pwmOut | output | 1 | PWM output |

## Verification
The hardest case to reach is a configuration write in the middle of a running period, because the period counter is not visible at the ports. The bench finds the start of a period by watching for the output rising with a large compare value. It then counts 100 cycles and writes a small compare value. It checks that the output stays active past the point where the new value would have ended it. Then it measures the following full period. Duty is measured by counting active cycles over a window of exactly one period, which gives an exact count wherever the window starts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;
  localparam int PS_LSB  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_STOP  = 2'd3
  } pwmState_t;

  typedef struct packed {
    logic run;
    logic hold;
  } pwmCtl_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enStrobe,
  input  logic    disStrobe,
  output pwmCtl_t ctl,
  output logic    statusRun
);
  localparam int LW = $clog2(LAT + 1);

  pwmState_t state;
  logic [LW-1:0] latCnt;
  logic latDone;

  assign latDone = (latCnt == LW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          latCnt <= '0;
          if (enStrobe && !disStrobe) state <= ST_START;
        end
        ST_START: begin
          if (disStrobe) begin
            state  <= ST_IDLE;
            latCnt <= '0;
          end else if (latDone) begin
            state  <= ST_RUN;
            latCnt <= '0;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        ST_RUN: begin
          latCnt <= '0;
          if (disStrobe) state <= ST_STOP;
        end
        ST_STOP: begin
          if (latDone) begin
            state  <= ST_IDLE;
            latCnt <= '0;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ctl.run    = (state == ST_RUN);
  assign ctl.hold   = (state != ST_RUN);
  assign statusRun  = (state == ST_RUN) || (state == ST_STOP);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int CMP_W  = 8,
  parameter int PS_W   = 3,
  parameter int PS_MAX = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             srcSys,
  input  logic             slowTick,
  input  logic             sysTick,
  input  pwmCtl_t          ctl,
  output logic             pwmOut,
  output logic             wrap,
  output logic [CMP_W-1:0] shCmp,
  output logic             shPol,
  output logic [CMP_W-1:0] periodCnt
);
  localparam logic [PS_W-1:0] PS_CLAMP = PS_W'(PS_MAX);

  logic [CFG_W-1:0] cfgUnused;
  logic [CMP_W-1:0] cfgCmp;
  logic             cfgPol;
  logic [PS_W-1:0]  cfgPs;
  logic [PS_W-1:0]  shPs;
  logic [PS_MAX-1:0] psCnt;
  logic [PS_MAX-1:0] psMask;
  logic srcTick, pTick, active;

  assign cfgUnused = cfgWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgCmp <= '0;
      cfgPol <= 1'b1;
      cfgPs  <= '0;
    end else if (cfgWr) begin
      cfgCmp <= cfgWdata[CMP_LSB +: CMP_W];
      cfgPol <= cfgWdata[POL_BIT];
      cfgPs  <= (cfgWdata[PS_LSB +: PS_W] > PS_CLAMP) ? PS_CLAMP
                                                      : cfgWdata[PS_LSB +: PS_W];
    end
  end

  assign srcTick = srcSys ? sysTick : slowTick;
  assign psMask  = PS_MAX'((32'd1 << shPs) - 32'd1);
  assign pTick   = srcTick && ((psCnt & psMask) == psMask);
  assign wrap    = pTick && (periodCnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.hold) begin
      psCnt     <= '0;
      periodCnt <= '0;
    end else begin
      if (srcTick) psCnt <= psCnt + 1'b1;
      if (pTick)   periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shCmp <= '0;
      shPol <= 1'b1;
      shPs  <= '0;
    end else if (ctl.hold || wrap) begin
      shCmp <= cfgCmp;
      shPol <= cfgPol;
      shPs  <= cfgPs;
    end
  end

  assign active = ctl.run && (periodCnt < shCmp);
  assign pwmOut = shPol ? active : !active;
endmodule

// File: rtl/pwm_backlight.sv
module pwm_backlight
  import pwm_pkg::*;
#(
  parameter int CFG_W  = 16,
  parameter int CMP_W  = 8,
  parameter int PS_W   = 3,
  parameter int PS_MAX = 6,
  parameter int LAT    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             srcSys,
  input  logic             slowTick,
  input  logic             sysTick,
  input  logic             enStrobe,
  input  logic             disStrobe,
  output logic             statusRun,
  output logic             pwmOut
);
  pwmCtl_t          ctl;
  logic             wrap;
  logic             shPol;
  logic [CMP_W-1:0] shCmp;
  logic [CMP_W-1:0] periodCnt;

  pwm_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .enStrobe(enStrobe), .disStrobe(disStrobe),
    .ctl(ctl), .statusRun(statusRun)
  );

  pwm_datapath #(
    .CFG_W(CFG_W), .CMP_W(CMP_W), .PS_W(PS_W), .PS_MAX(PS_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .srcSys(srcSys), .slowTick(slowTick), .sysTick(sysTick),
    .ctl(ctl), .pwmOut(pwmOut), .wrap(wrap),
    .shCmp(shCmp), .shPol(shPol), .periodCnt(periodCnt)
  );
endmodule

// File: rtl/pwm_backlight_checker.sv
module pwm_backlight_checker #(
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enStrobe,
  input logic             disStrobe,
  input logic             statusRun,
  input logic             pwmOut,
  input logic             run,
  input logic             wrap,
  input logic             shPol,
  input logic [CMP_W-1:0] shCmp,
  input logic [CMP_W-1:0] periodCnt
);
  assert_idle_inactive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (pwmOut == !shPol));

  assert_hold_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (periodCnt == '0));

  assert_rise_running_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusRun) |-> run);

  assert_shadow_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(wrap)) |-> $stable(shCmp));

  assert_dis_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (enStrobe && disStrobe) |=> !run);

  assert_zero_cmp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && shCmp == '0) |-> (pwmOut == !shPol));
endmodule

bind pwm_backlight pwm_backlight_checker #(.CMP_W(CMP_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .enStrobe(enStrobe), .disStrobe(disStrobe),
  .statusRun(statusRun), .pwmOut(pwmOut),
  .run(ctl.run), .wrap(wrap), .shPol(shPol),
  .shCmp(shCmp), .periodCnt(periodCnt)
);

// File: tb/pwm_backlight_bench.sv
`timescale 1ns/1ps
module pwm_backlight_bench;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic srcSys = 1'b1;
  logic slowTick = 1'b0;
  logic sysTick = 1'b1;
  logic enStrobe = 1'b0;
  logic disStrobe = 1'b0;
  logic statusRun, pwmOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  always @(negedge clk) slowTick <= ~slowTick;

  pwm_backlight #(.LAT(LAT)) u_pwm_backlight (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata),
    .srcSys(srcSys), .slowTick(slowTick), .sysTick(sysTick),
    .enStrobe(enStrobe), .disStrobe(disStrobe),
    .statusRun(statusRun), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input int cmp, input bit pol, input int ps);
    @(negedge clk);
    cfgWdata = {8'(cmp), 3'b0, pol, 1'b0, 3'(ps)};
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic strobe(input bit en, input bit dis);
    @(negedge clk);
    enStrobe = en;
    disStrobe = dis;
    @(negedge clk);
    enStrobe = 1'b0;
    disStrobe = 1'b0;
  endtask

  task automatic edgesUntil(input bit v, output int n);
    n = 1;
    while (statusRun != v && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input int window, output int hi);
    hi = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  task automatic stopGen();
    int n;
    if (statusRun) begin
      strobe(1'b0, 1'b1);
      edgesUntil(1'b0, n);
    end
  endtask

  task automatic startGen();
    int n;
    strobe(1'b1, 1'b0);
    edgesUntil(1'b1, n);
  endtask

  task automatic runDuty(input int cmp, input bit pol, input int ps,
                         input int window, input int expHi, input string req);
    int hi;
    stopGen();
    writeCfg(cmp, pol, ps);
    startGen();
    measure(window, hi);
    check(hi == expHi, req, hi, expHi);
  endtask

  task automatic testReset();
    check(statusRun == 1'b0, "R2 status after reset", statusRun, 0);
    check(pwmOut == 1'b0, "R2 R1 output after reset", pwmOut, 0);
  endtask

  task automatic testEnable();
    int n;
    writeCfg(128, 1'b1, 0);
    strobe(1'b1, 1'b0);
    check(statusRun == 1'b0, "R9 status low right after strobe", statusRun, 0);
    edgesUntil(1'b1, n);
    check(n == LAT + 1, "R9 start latency", n, LAT + 1);
  endtask

  task automatic testDuty();
    runDuty(64, 1'b1, 0, 256, 64, "R3 compare 64");
    runDuty(0, 1'b1, 0, 256, 0, "R3 compare 0");
    runDuty(255, 1'b1, 0, 256, 255, "R3 compare 255");
    runDuty(64, 1'b0, 0, 256, 192, "R4 inverted polarity");
    runDuty(0, 1'b0, 0, 256, 256, "R4 inverted compare 0");
  endtask

  task automatic testFieldWord();
    int hi;
    stopGen();
    @(negedge clk);
    cfgWdata = 16'h4012;
    cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
    startGen();
    measure(1024, hi);
    check(hi == 256, "R1 raw word 0x4012", hi, 256);
  endtask

  task automatic testPrescale();
    runDuty(10, 1'b1, 2, 1024, 40, "R5 exponent 2");
    runDuty(3, 1'b1, 6, 16384, 192, "R5 exponent 6");
    runDuty(3, 1'b1, 7, 16384, 192, "R6 exponent 7 as 6");
  endtask

  task automatic testSource();
    srcSys = 1'b0;
    runDuty(64, 1'b1, 0, 512, 128, "R7 slow tick source");
    srcSys = 1'b1;
    runDuty(64, 1'b1, 0, 256, 64, "R7 system tick source");
  endtask

  task automatic testShadow();
    int hi;
    int guard;
    stopGen();
    writeCfg(200, 1'b1, 0);
    startGen();
    guard = 0;
    while (pwmOut && guard < 600) begin @(negedge clk); guard++; end
    while (!pwmOut && guard < 600) begin @(negedge clk); guard++; end
    repeat (100) @(negedge clk);
    writeCfg(50, 1'b1, 0);
    repeat (5) @(negedge clk);
    check(pwmOut == 1'b1, "R8 old compare held mid-period", pwmOut, 1);
    repeat (300) @(negedge clk);
    measure(256, hi);
    check(hi == 50, "R8 new compare after wrap", hi, 50);
  endtask

  task automatic testDisable();
    int n;
    stopGen();
    writeCfg(255, 1'b1, 0);
    startGen();
    repeat (3) @(negedge clk);
    strobe(1'b0, 1'b1);
    check(pwmOut == 1'b0, "R10 output inactive after stop", pwmOut, 0);
    check(statusRun == 1'b1, "R10 status held during stop", statusRun, 1);
    edgesUntil(1'b0, n);
    check(n == LAT + 1, "R10 stop latency", n, LAT + 1);
  endtask

  task automatic testIdleLevel();
    writeCfg(255, 1'b0, 0);
    @(negedge clk);
    check(pwmOut == 1'b1, "R11 idle level polarity 0", pwmOut, 1);
    writeCfg(255, 1'b1, 0);
    @(negedge clk);
    check(pwmOut == 1'b0, "R11 idle level polarity 1", pwmOut, 0);
  endtask

  task automatic testBoth();
    int hi;
    writeCfg(255, 1'b1, 0);
    strobe(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check(statusRun == 1'b0, "R12 disable wins status", statusRun, 0);
    measure(20, hi);
    check(hi == 0, "R12 disable wins output", hi, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired before all R checks ran");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testDuty();
    testFieldWord();
    testPrescale();
    testSource();
    testShadow();
    testDisable();
    testIdleLevel();
    testBoth();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule